// File: doc/BRIEF.md
# Shared Mailbox Dual-Port RAM with Read-Address Hold

This block is a synchronous true dual-port RAM that two processors use as a shared mailbox. Port A is wired tightly to one processor and issues a read on every cycle, whether or not the access was meant for this memory. Port B sits behind a bus that can stall it. Both ports can read and write, and each write carries per-byte lane enables.

Each port has an active-high hold input that is the inverse of a clock enable. While hold is high, the port reuses the read address it captured earlier. The array is still read every cycle at that held address, and the clock always runs. So a bus read that is stretched by a stall still returns data for its own address on the cycle after the stall ends.

A read on one port in the same cycle as a write to that word on the other port returns the complete previous word, never a mix of old and new bits. The same holds for a read and a write on one port. If both ports write one word in the same cycle, port A's write takes effect.

Top module: `mailbox_dpram`

## Requirements
- R1: A write commits at the rising clock edge on every byte lane whose bit in the port's byte-enable vector is 1. Bit k covers data bits 8k+7..8k. Lanes whose bit is 0 keep their previous contents.
- R2: Read latency is one cycle. With hold low at edge k, the read data after edge k is the word at the address presented at edge k, as stored before any write at edge k.
- R3: When one port reads a word at the same edge at which the other port writes it, the read returns the complete old word. The next read after that edge returns the complete new word.
- R4: A read and a write on the same port to the same word at one edge return the old word.
- R5: While hold is high at edge k, the port reads the address it used at edge k-1, not the address on its input. The result reflects the array contents at edge k, including writes committed at earlier edges.
- R6: At the first edge where hold is low again, the port captures and reads the address on its input, and it no longer uses the held address.
- R7: A port's hold input affects only read-address capture. A write on that port still commits at the edge, at the address on its input.
- R8: When both ports write the same address at the same edge, port A's write is stored and port B's write is dropped entirely.
- R9: While reset is high, both read-data outputs are 0 and both held read addresses return to 0.
- R10: Reads have no side effects. Any number of reads on either port leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| pa_addr | input | ADDR_W | Port A word address |
| pa_wdata | input | DATA_W | Port A write data |
| pa_ben | input | BE_W | Port A byte-lane write enables |
| pa_wen | input | 1 | Port A write request |
| pa_stall | input | 1 | Port A read-address hold, active high |
| pa_rdata | output | DATA_W | Port A registered read data |
| pb_addr | input | ADDR_W | Port B word address |
| pb_wdata | input | DATA_W | Port B write data |
| pb_ben | input | BE_W | Port B byte-lane write enables |
| pb_wen | input | 1 | Port B write request |
| pb_stall | input | 1 | Port B read-address hold, active high |
| pb_rdata | output | DATA_W | Port B registered read data |

## Verification
The bench builds the block with 32-bit words and a depth of 64. At that depth it can write and read back every word, including the top address, and its model can track the whole array across thousands of cycles.

The 32-bit width gives four byte lanes. With four lanes, partial-enable patterns and a torn word would show up as a mismatch against the expected value.

The pointer phase puts periodic port A updates of one word against port B polling that word with random holds. This drives many cross-port same-word collisions, and many collisions that coincide with a held address.

// File: rtl/mailbox_pkg.sv
package mailbox_pkg;
  localparam int unsigned LANE_W      = 8;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_DEPTH   = 1024;

  function automatic int unsigned lanes_for(input int unsigned data_w);
    return data_w / LANE_W;
  endfunction
endpackage

// File: rtl/mailbox_addr_hold.sv
module mailbox_addr_hold #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_eff
);
  logic [ADDR_W-1:0] addr_q;

  // the held address is reused while stall is high; the array is still read
  assign addr_eff = stall ? addr_q : addr_in;

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_eff;
  end
endmodule

// File: rtl/mailbox_wr_arb.sv
module mailbox_wr_arb #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned BE_W   = 4
) (
  input  logic              a_wen,
  input  logic [BE_W-1:0]   a_ben,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_wen,
  input  logic [BE_W-1:0]   b_ben,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [BE_W-1:0]   a_lane_we,
  output logic [BE_W-1:0]   b_lane_we
);
  logic b_drop;

  always_comb begin
    b_drop    = a_wen && b_wen && (a_addr == b_addr);
    a_lane_we = a_wen ? a_ben : '0;
    b_lane_we = (b_wen && !b_drop) ? b_ben : '0;
  end
endmodule

// File: rtl/mailbox_lane_ram.sv
module mailbox_lane_ram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_waddr,
  input  logic [LANE_W-1:0] a_wd,
  input  logic [ADDR_W-1:0] a_raddr,
  output logic [LANE_W-1:0] a_rd,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_waddr,
  input  logic [LANE_W-1:0] b_wd,
  input  logic [ADDR_W-1:0] b_raddr,
  output logic [LANE_W-1:0] b_rd
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_waddr] <= a_wd;
    if (b_we) mem[b_waddr] <= b_wd;
  end

  // registered reads sample the array before this edge's writes land
  always_ff @(posedge clk) begin
    if (rst) begin
      a_rd <= '0;
      b_rd <= '0;
    end else begin
      a_rd <= mem[a_raddr];
      b_rd <= mem[b_raddr];
    end
  end
endmodule

// File: rtl/mailbox_dpram.sv
module mailbox_dpram #(
  parameter int unsigned DATA_W = mailbox_pkg::DEF_DATA_W,
  parameter int unsigned DEPTH  = mailbox_pkg::DEF_DEPTH,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned BE_W   = mailbox_pkg::lanes_for(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pa_addr,
  input  logic [DATA_W-1:0] pa_wdata,
  input  logic [BE_W-1:0]   pa_ben,
  input  logic              pa_wen,
  input  logic              pa_stall,
  output logic [DATA_W-1:0] pa_rdata,
  input  logic [ADDR_W-1:0] pb_addr,
  input  logic [DATA_W-1:0] pb_wdata,
  input  logic [BE_W-1:0]   pb_ben,
  input  logic              pb_wen,
  input  logic              pb_stall,
  output logic [DATA_W-1:0] pb_rdata
);
  localparam int unsigned LW = mailbox_pkg::LANE_W;

  logic [ADDR_W-1:0] a_raddr, b_raddr;
  logic [BE_W-1:0]   a_lane_we, b_lane_we;

  mailbox_addr_hold #(.ADDR_W(ADDR_W)) u_hold_a (
    .clk(clk), .rst(rst), .stall(pa_stall), .addr_in(pa_addr), .addr_eff(a_raddr)
  );

  mailbox_addr_hold #(.ADDR_W(ADDR_W)) u_hold_b (
    .clk(clk), .rst(rst), .stall(pb_stall), .addr_in(pb_addr), .addr_eff(b_raddr)
  );

  mailbox_wr_arb #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_arb (
    .a_wen(pa_wen), .a_ben(pa_ben), .a_addr(pa_addr),
    .b_wen(pb_wen), .b_ben(pb_ben), .b_addr(pb_addr),
    .a_lane_we(a_lane_we), .b_lane_we(b_lane_we)
  );

  for (genvar l = 0; l < BE_W; l++) begin : g_lane
    logic [LW-1:0] a_rd_l, b_rd_l;

    mailbox_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LW)) u_lane (
      .clk(clk), .rst(rst),
      .a_we(a_lane_we[l]), .a_waddr(pa_addr), .a_wd(pa_wdata[l*LW +: LW]),
      .a_raddr(a_raddr), .a_rd(a_rd_l),
      .b_we(b_lane_we[l]), .b_waddr(pb_addr), .b_wd(pb_wdata[l*LW +: LW]),
      .b_raddr(b_raddr), .b_rd(b_rd_l)
    );

    assign pa_rdata[l*LW +: LW] = a_rd_l;
    assign pb_rdata[l*LW +: LW] = b_rd_l;
  end
endmodule

// File: rtl/mailbox_dpram_chk.sv
module mailbox_dpram_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] pa_addr,
  input logic [DATA_W-1:0] pa_wdata,
  input logic [BE_W-1:0]   pa_ben,
  input logic              pa_wen,
  input logic              pa_stall,
  input logic [DATA_W-1:0] pa_rdata,
  input logic [ADDR_W-1:0] pb_addr,
  input logic [DATA_W-1:0] pb_wdata,
  input logic [BE_W-1:0]   pb_ben,
  input logic              pb_wen,
  input logic              pb_stall,
  input logic [DATA_W-1:0] pb_rdata
);
  // R9: outputs cleared by reset
  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (pa_rdata == '0 && pb_rdata == '0));

  // R5: held address with no intervening write keeps the same data
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (pb_stall && !$past(rst) && !$past(pa_wen) && !$past(pb_wen)) |=> $stable(pb_rdata));

  // R1: full-word write on A is read back by A on the next edge
  p_write_readback_r1: assert property (@(posedge clk) disable iff (rst)
    (pa_wen && !pa_stall && pa_ben == '1) ##1 (!pa_stall && pa_addr == $past(pa_addr))
    |=> (pa_rdata == $past(pa_wdata, 2)));

  // R7: a write while A holds its read address still commits
  p_stall_write_r7: assert property (@(posedge clk) disable iff (rst)
    (pa_wen && pa_stall && pa_ben == '1) ##1 (!pa_stall && pa_addr == $past(pa_addr))
    |=> (pa_rdata == $past(pa_wdata, 2)));

  // R8: same-address double write keeps port A's word
  p_a_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (pa_wen && pb_wen && pa_addr == pb_addr && pa_ben == '1)
    ##1 (!pb_stall && pb_addr == $past(pb_addr))
    |=> (pb_rdata == $past(pa_wdata, 2)));
endmodule

bind mailbox_dpram mailbox_dpram_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
) u_chk (
  .clk(clk), .rst(rst),
  .pa_addr(pa_addr), .pa_wdata(pa_wdata), .pa_ben(pa_ben), .pa_wen(pa_wen),
  .pa_stall(pa_stall), .pa_rdata(pa_rdata),
  .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_ben(pb_ben), .pb_wen(pb_wen),
  .pb_stall(pb_stall), .pb_rdata(pb_rdata)
);

// File: tb/tb_mailbox_dpram.sv
`timescale 1ns/1ps
module tb_mailbox_dpram;
  localparam int DW = 32;
  localparam int DEPTH = 64;
  localparam int AW = 6;
  localparam int BW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic [AW-1:0] pa_addr, pb_addr;
  logic [DW-1:0] pa_wdata, pb_wdata, pa_rdata, pb_rdata;
  logic [BW-1:0] pa_ben, pb_ben;
  logic pa_wen, pb_wen, pa_stall, pb_stall;

  mailbox_dpram #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst),
    .pa_addr(pa_addr), .pa_wdata(pa_wdata), .pa_ben(pa_ben), .pa_wen(pa_wen),
    .pa_stall(pa_stall), .pa_rdata(pa_rdata),
    .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_ben(pb_ben), .pb_wen(pb_wen),
    .pb_stall(pb_stall), .pb_rdata(pb_rdata)
  );

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mdl [DEPTH];
  int hold_a = 0, hold_b = 0;

  logic [DW-1:0] qa_val[$], qb_val[$];
  string qa_tag[$], qb_tag[$];

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [BW-1:0] be);
    logic [DW-1:0] r = old;
    for (int k = 0; k < BW; k++) if (be[k]) r[k*8 +: 8] = nw[k*8 +: 8];
    return r;
  endfunction

  // driver: called at a falling edge, predicts results and applies one cycle
  task automatic step(input int aa, input logic [DW-1:0] ad, input logic [BW-1:0] ab,
                      input bit aw, input bit as, input string ta,
                      input int ba, input logic [DW-1:0] bd, input logic [BW-1:0] bb,
                      input bit bw, input bit bs, input string tb);
    int ea, eb;
    pa_addr = AW'(aa); pa_wdata = ad; pa_ben = ab; pa_wen = aw; pa_stall = as;
    pb_addr = AW'(ba); pb_wdata = bd; pb_ben = bb; pb_wen = bw; pb_stall = bs;
    ea = as ? hold_a : aa;
    eb = bs ? hold_b : ba;
    hold_a = ea; hold_b = eb;
    if (ta != "") begin qa_val.push_back(mdl[ea]); qa_tag.push_back(ta); end
    if (tb != "") begin qb_val.push_back(mdl[eb]); qb_tag.push_back(tb); end
    if (bw && !(aw && aa == ba)) mdl[ba] = merge(mdl[ba], bd, bb);
    if (aw) mdl[aa] = merge(mdl[aa], ad, ab);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_both(input int aa, input string ta, input int ba, input string tb);
    step(aa, '0, '0, 0, 0, ta, ba, '0, '0, 0, 0, tb);
  endtask

  task automatic do_reset();
    pa_wen = 0; pb_wen = 0; pa_stall = 0; pb_stall = 0;
    pa_ben = '0; pb_ben = '0; pa_wdata = '0; pb_wdata = '0;
    pa_addr = 7; pb_addr = 9;
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 reset pa_rdata", pa_rdata, '0);
    check("R9 reset pb_rdata", pb_rdata, '0);
    rst = 0;
    hold_a = 0; hold_b = 0;
  endtask

  // monitor: pops predictions and compares just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (qa_val.size() > 0) check(qa_tag.pop_front(), pa_rdata, qa_val.pop_front());
      if (qb_val.size() > 0) check(qb_tag.pop_front(), pb_rdata, qb_val.pop_front());
    end
  end

  bit done = 0;

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // fill the whole array from port A, top address included (R1)
    for (int i = 0; i < DEPTH; i++)
      step(i, 32'hA500_0000 + DW'(i * 32'h0101), 4'hF, 1, 0, "", 0, '0, '0, 0, 0, "");
    for (int i = 0; i < DEPTH; i++)
      idle_both(DEPTH - 1 - i, "R2 latency port A", i, "R1 readback port B");

    // partial byte enables (R1)
    step(10, 32'h1122_3344, 4'b0101, 1, 0, "", 0, '0, '0, 0, 0, "");
    step(11, '0, '0, 0, 0, "", 12, 32'hDEAD_BEEF, 4'b1000, 1, 0, "");
    idle_both(10, "R1 byte lanes A", 12, "R1 byte lanes B");

    // same-port read during write (R4)
    step(20, 32'h2020_2020, 4'hF, 1, 0, "R4 same-port old", 0, '0, '0, 0, 0, "");
    idle_both(20, "R4 new after", 0, "");
    step(33, '0, '0, 0, 0, "", 34, 32'h3434_0000, 4'hF, 1, 0, "R4 same-port old B");

    // cross-port read during write (R3)
    step(21, 32'hCAFE_F00D, 4'hF, 1, 0, "", 21, '0, '0, 0, 0, "R3 cross old");
    idle_both(0, "", 21, "R3 cross new");
    step(22, '0, '0, 0, 0, "R3 cross old A", 22, 32'h0BAD_CAFE, 4'hF, 1, 0, "");
    idle_both(22, "R3 cross new A", 0, "");

    // simultaneous write to one word (R8)
    step(23, 32'hAAAA_0001, 4'hF, 1, 0, "", 23, 32'hBBBB_0002, 4'hF, 1, 0, "");
    idle_both(23, "R8 A wins A", 23, "R8 A wins B");
    step(24, 32'h0000_00AA, 4'b0001, 1, 0, "", 24, 32'hBB00_0000, 4'b1000, 1, 0, "");
    idle_both(24, "R8 B dropped", 0, "");

    // address hold on port B (R5, R6)
    idle_both(0, "", 30, "R2 before hold");
    idle_both(0, "", 40, "R5 held data");
    step(30, 32'h3030_3030, 4'hF, 1, 0, "", 41, '0, '0, 0, 1, "R5 held old");
    idle_both(0, "", 42, "R5 held reread");
    idle_both(0, "", 40, "R6 release");
    idle_both(0, "", 43, "R6 new addr");

    // write while holding (R7), hold on port A (R5)
    idle_both(44, "", 0, "");
    step(45, 32'h4545_4545, 4'hF, 1, 1, "R5 A held", 45, '0, '0, 0, 0, "R7 before");
    step(46, 32'h4646_0000, 4'b1100, 1, 1, "R5 A held again", 45, '0, '0, 0, 1, "");
    idle_both(45, "R7 A", 46, "R7 B");

    // reads leave contents unchanged (R10)
    for (int i = 0; i < 40; i++)
      step(50 + (i % 5), '0, '0, 0, (i % 3) == 0, "", 50 + (i % 7), '0, '0, 0, (i % 4) == 0, "");
    for (int i = 0; i < 8; i++) idle_both(50 + i, "R10 no side effect A", 57 - i, "R10 no side effect B");

    // reset clears held addresses (R9)
    do_reset();
    step(5, '0, '0, 0, 1, "R9 held addr A", 9, '0, '0, 0, 1, "R9 held addr B");

    // pointer update against polling reader with random holds (R3, R5)
    begin
      logic [DW-1:0] ptr;
      ptr = 32'h0001_5460;
      for (int i = 0; i < 3000; i++) begin
        bit wr = (i % 4) == 0;
        bit st = ($urandom % 10) < 3;
        if (wr) ptr = ptr + 32'h20;
        step(wr ? 5 : int'($urandom % DEPTH), ptr, 4'hF, wr, 0, wr ? "" : "R2 poll A",
             5, '0, '0, 0, st, st ? "R5 poll held" : "R3 poll");
      end
    end

    idle_both(0, "", 0, "");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule